// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sends one command to a memory card each time software writes the command register with its enable bit set. The argument register and the command register load from a simple write interface. An accepted command appears on the card side as a one-cycle strobe that carries the 6-bit index and the 32-bit argument. The block then waits for the card's reply, which arrives as a byte count and up to sixteen bytes. While it waits, the block raises `busy`.

When the reply arrives, the block checks the byte count against the kind of response the command asked for. A reply that passes is packed big-endian into four 32-bit response words, and the block sets one of three result flags: response-end, command-sent or timeout. A reply with the wrong length, or a rejection from the card, is reported as a timeout. In both of those cases the response words are left unchanged. The enable bit clears itself when the command completes. A command written with the pending bit set is never issued, but its enable bit still clears.

Top module: `cmd_resp_capture`

## Requirements
- R1: After reset, `arg_q`, `cmd_q`, `rsp_words`, `busy`, `card_cmd_valid` and all three flags are zero.
- R2: The command register layout is: index in bits [5:0], response-expected in bit 6, long-response in bit 7, pending in bit 9, enable in bit 10. While idle, a write with enable=1 and pending=0 gives `card_cmd_valid` high for exactly the next cycle, with `card_cmd_index` = bits [5:0] and `card_cmd_arg` = `arg_q`. `busy` is high from that cycle until the cycle in which the response is taken.
- R3: In the cycle after the response is taken, `busy` is 0 and bit 10 of `cmd_q` reads 0, whatever the outcome. All other command bits keep their written values.
- R4: A command write with bits 10 and 9 both set produces no strobe and no busy. It is stored with bit 10 cleared and bit 9 set.
- R5: A short response (response expected, long not requested, length 4) sets `flag_rsp_end`. Word 0 takes `card_rsp_data[127:96]`, so the first byte, `card_rsp_data[127:120]`, lands in bits [31:24]. Words 1 to 3 become zero. Word k is `rsp_words[32k+31:32k]`.
- R6: A 16-byte response with response expected sets `flag_rsp_end`, whether or not long was requested. Word k takes `card_rsp_data[127-32k -: 32]`, and bit 0 of word 3 is forced to 0.
- R7: With response expected, a length of 0, a length of 4 on a long request, or any length other than 4 or 16 sets `flag_timeout` and leaves `rsp_words` unchanged.
- R8: With no response expected and no rejection, `flag_sent` is set and `rsp_words` is unchanged.
- R9: When `card_rsp_reject` is high with the response, `flag_timeout` is set and `rsp_words` is unchanged, whatever the length.
- R10: While `busy` is high, writes to the argument and command registers are ignored. No further strobe follows.
- R11: At most one flag is set at a time. All three flags clear when a command is accepted for issue, and otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write value |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command write value |
| arg_q | output | 32 | Argument register contents |
| cmd_q | output | 32 | Command register contents |
| busy | output | 1 | A command is in flight |
| card_cmd_valid | output | 1 | One-cycle command strobe to the card |
| card_cmd_index | output | 6 | Command index |
| card_cmd_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | Card reply present |
| card_rsp_reject | input | 1 | Card rejected the command |
| card_rsp_len | input | 5 | Reply byte count |
| card_rsp_data | input | 128 | Reply bytes, first byte in [127:120] |
| rsp_words | output | 128 | Response words, word k at [32k+31:32k] |
| flag_rsp_end | output | 1 | Valid response captured |
| flag_sent | output | 1 | Command issued, no response expected |
| flag_timeout | output | 1 | Rejected or bad-length response |

## Verification
The assertions check properties that must hold on every cycle. The card strobe lasts exactly one cycle, and each accepted write is followed by a strobe. No more than one flag is ever set, and every completion sets some flag. The enable bit has dropped in the cycle after completion, and the argument register holds still while busy. Only the bench's scenarios can show that the words are packed right and that each length and direction combination gives the right flag. The same holds for words staying unchanged on failure, for pending commands being suppressed, and for the command register ignoring writes made while busy.

// File: rtl/cmd_resp_pkg.sv
// Shared constants and types for the command issue and response capture block.
// Assumes a 32-bit register width and byte-oriented responses.
package cmd_resp_pkg;
    localparam int REG_W     = 32;
    localparam int IDX_W     = 6;
    localparam int BIT_RESP  = 6;
    localparam int BIT_LONG  = 7;
    localparam int BIT_PEND  = 9;
    localparam int BIT_EN    = 10;
    localparam int SHORT_LEN = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/cmd_regs.sv
// Argument and command registers.
// Writes are ignored while busy. A pending command is stored with enable
// cleared. Enable clears when the sequencer reports completion.
module cmd_regs
    import cmd_resp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             done,
    input  logic             arg_we,
    input  logic [REG_W-1:0] arg_wdata,
    input  logic             cmd_we,
    input  logic [REG_W-1:0] cmd_wdata,
    output logic [REG_W-1:0] arg_q,
    output logic [REG_W-1:0] cmd_q,
    output logic             start
);
    logic wr_ok;

    // Purpose: decide whether a write is allowed and whether it launches a command.
    always_comb begin
        wr_ok = cmd_we && !busy;
        start = wr_ok && cmd_wdata[BIT_EN] && !cmd_wdata[BIT_PEND];
    end

    // Purpose: hold the argument register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arg_q <= '0;
        else if (arg_we && !busy)
            arg_q <= arg_wdata;
    end

    // Purpose: hold the command register and self-clear its enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_ok) begin
            cmd_q <= cmd_wdata;
            if (cmd_wdata[BIT_PEND])
                cmd_q[BIT_EN] <= 1'b0;
        end else if (done) begin
            cmd_q[BIT_EN] <= 1'b0;
        end
    end

    // R10
    arg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && arg_we) |=> $stable(arg_q));

    // R3
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !cmd_q[BIT_EN]);
endmodule

// File: rtl/cmd_seq.sv
// Command sequencer: idle, then one issue cycle, then wait for the card's reply.
// Assumes the card answers only after it has seen the strobe.
module cmd_seq
    import cmd_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rsp_valid,
    output logic issue,
    output logic busy,
    output logic done
);
    seq_state_t state_q, state_d;

    // Purpose: next-state logic and decoded outputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start) state_d = SEQ_ISSUE;
            SEQ_ISSUE: state_d = SEQ_WAIT;
            SEQ_WAIT:  if (rsp_valid) state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
        issue = (state_q == SEQ_ISSUE);
        busy  = (state_q != SEQ_IDLE);
        done  = (state_q == SEQ_WAIT) && rsp_valid;
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // R2
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);

    // R2
    start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (issue && busy));
endmodule

// File: rtl/rsp_eval.sv
// Combinational response check and big-endian word packing.
// Assumes the first byte received sits in the top byte of the data bus.
module rsp_eval
    import cmd_resp_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int LEN_W = 5
)(
    input  logic                   resp_exp,
    input  logic                   long_req,
    input  logic                   reject,
    input  logic [LEN_W-1:0]       len,
    input  logic [WORDS*REG_W-1:0] data,
    output logic                   fail,
    output logic [WORDS*REG_W-1:0] words
);
    localparam int FULL_LEN = WORDS * 4;

    logic is_short, is_full;

    // Purpose: classify the byte count and decide pass or fail.
    always_comb begin
        is_short = (len == LEN_W'(SHORT_LEN));
        is_full  = (len == LEN_W'(FULL_LEN));
        fail     = reject ||
                   (resp_exp && ((len == '0) || (is_short && long_req) ||
                                 (!is_short && !is_full)));
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_pack
        localparam int SRC = (WORDS - 1 - g) * REG_W;
        if (g == 0) begin : g_first
            // Purpose: word 0 always takes the first four bytes.
            always_comb words[REG_W-1:0] = data[SRC +: REG_W];
        end else if (g == WORDS - 1) begin : g_last
            // Purpose: last word, low bit forced to zero, zero for a short reply.
            always_comb
                words[g*REG_W +: REG_W] = is_full ?
                    {data[SRC+1 +: REG_W-1], 1'b0} : '0;
        end else begin : g_mid
            // Purpose: middle words, zero for a short reply.
            always_comb
                words[g*REG_W +: REG_W] = is_full ? data[SRC +: REG_W] : '0;
        end
    end
endmodule

// File: rtl/rsp_store.sv
// Result registers: response words and the three outcome flags.
// Flags clear when a command is accepted and one is set on completion.
module rsp_store
    import cmd_resp_pkg::*;
#(
    parameter int WORDS = 4
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   done,
    input  logic                   resp_exp,
    input  logic                   fail,
    input  logic [WORDS*REG_W-1:0] words_in,
    output logic [WORDS*REG_W-1:0] words_q,
    output logic                   flag_end,
    output logic                   flag_sent,
    output logic                   flag_to
);
    // Purpose: capture the words of a valid reply.
    always_ff @(posedge clk) begin
        if (!rst_n)
            words_q <= '0;
        else if (done && resp_exp && !fail)
            words_q <= words_in;
    end

    // Purpose: clear the flags on issue and record the outcome on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_end  <= 1'b0;
            flag_sent <= 1'b0;
            flag_to   <= 1'b0;
        end else if (start) begin
            flag_end  <= 1'b0;
            flag_sent <= 1'b0;
            flag_to   <= 1'b0;
        end else if (done) begin
            flag_to   <= fail;
            flag_end  <= !fail && resp_exp;
            flag_sent <= !fail && !resp_exp;
        end
    end

    // R11
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_end, flag_sent, flag_to}));

    // R11
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (flag_end || flag_sent || flag_to));
endmodule

// File: rtl/cmd_resp_capture.sv
// Top: issues one card command per enabled command write, captures the reply.
// Assumes one reply per issued command, presented as a single-cycle beat.
module cmd_resp_capture
    import cmd_resp_pkg::*;
#(
    parameter int RSP_WORDS = 4,
    parameter int LEN_W     = $clog2(RSP_WORDS * 4 + 1)
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arg_we,
    input  logic [31:0]                arg_wdata,
    input  logic                       cmd_we,
    input  logic [31:0]                cmd_wdata,
    output logic [31:0]                arg_q,
    output logic [31:0]                cmd_q,
    output logic                       busy,
    output logic                       card_cmd_valid,
    output logic [5:0]                 card_cmd_index,
    output logic [31:0]                card_cmd_arg,
    input  logic                       card_rsp_valid,
    input  logic                       card_rsp_reject,
    input  logic [LEN_W-1:0]           card_rsp_len,
    input  logic [RSP_WORDS*32-1:0]    card_rsp_data,
    output logic [RSP_WORDS*32-1:0]    rsp_words,
    output logic                       flag_rsp_end,
    output logic                       flag_sent,
    output logic                       flag_timeout
);
    logic start, done, fail;
    logic [RSP_WORDS*REG_W-1:0] packed_words;

    cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
        .arg_we(arg_we), .arg_wdata(arg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .arg_q(arg_q), .cmd_q(cmd_q), .start(start)
    );

    cmd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rsp_valid(card_rsp_valid),
        .issue(card_cmd_valid), .busy(busy), .done(done)
    );

    rsp_eval #(.WORDS(RSP_WORDS), .LEN_W(LEN_W)) u_eval (
        .resp_exp(cmd_q[BIT_RESP]), .long_req(cmd_q[BIT_LONG]),
        .reject(card_rsp_reject), .len(card_rsp_len), .data(card_rsp_data),
        .fail(fail), .words(packed_words)
    );

    rsp_store #(.WORDS(RSP_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .resp_exp(cmd_q[BIT_RESP]), .fail(fail), .words_in(packed_words),
        .words_q(rsp_words), .flag_end(flag_rsp_end),
        .flag_sent(flag_sent), .flag_to(flag_timeout)
    );

    // Purpose: present the held index and argument to the card.
    always_comb begin
        card_cmd_index = cmd_q[IDX_W-1:0];
        card_cmd_arg   = arg_q;
    end
endmodule

// File: tb/cmd_resp_capture_tb_top.sv
module cmd_resp_capture_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arg_we = 0, cmd_we = 0;
    logic [31:0] arg_wdata = '0, cmd_wdata = '0;
    logic [31:0] arg_q, cmd_q, card_cmd_arg;
    logic busy, card_cmd_valid;
    logic [5:0] card_cmd_index;
    logic card_rsp_valid = 0, card_rsp_reject = 0;
    logic [4:0] card_rsp_len = '0;
    logic [127:0] card_rsp_data = '0;
    logic [127:0] rsp_words;
    logic flag_rsp_end, flag_sent, flag_timeout;

    int checks = 0, failures = 0, cycles = 0;
    logic [127:0] model_w = '0;

    always #5 clk = ~clk;

    cmd_resp_capture dut_i (.*);

    typedef struct packed {
        logic         resp;
        logic         lng;
        logic         rej;
        logic [4:0]   len;
        logic [127:0] data;
        logic [1:0]   outcome; // 0 rsp_end, 1 sent, 2 timeout
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 5'd4,  128'hA1B2C3D4_11111111_22222222_33333333, 2'd0}, // R5
        '{1'b1, 1'b1, 1'b0, 5'd16, 128'h01020304_05060708_090A0B0C_0D0E0F11, 2'd0}, // R6
        '{1'b1, 1'b1, 1'b0, 5'd4,  128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 2'd2}, // R7
        '{1'b1, 1'b0, 1'b0, 5'd0,  128'hEEEEEEEE_EEEEEEEE_EEEEEEEE_EEEEEEEE, 2'd2}, // R7
        '{1'b1, 1'b0, 1'b0, 5'd7,  128'hDDDDDDDD_DDDDDDDD_DDDDDDDD_DDDDDDDD, 2'd2}, // R7
        '{1'b0, 1'b0, 1'b0, 5'd0,  128'hCCCCCCCC_CCCCCCCC_CCCCCCCC_CCCCCCCC, 2'd1}, // R8
        '{1'b1, 1'b0, 1'b1, 5'd4,  128'hBBBBBBBB_BBBBBBBB_BBBBBBBB_BBBBBBBB, 2'd2}, // R9
        '{1'b1, 1'b0, 1'b0, 5'd16, 128'h89ABCDEF_76543210_FEDCBA98_00000003, 2'd0}, // R6
        '{1'b0, 1'b0, 1'b1, 5'd0,  128'h0, 2'd2}                                   // R9
    };

    task automatic chk(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected words after a response, derived from R5..R9.
    function automatic logic [127:0] next_words(input vec_t v, input logic [127:0] prev);
        logic [127:0] w;
        w = prev;
        if (v.outcome == 2'd0) begin
            if (v.len == 5'd4) w = {96'h0, v.data[127:96]};
            else begin
                w[31:0]   = v.data[127:96];
                w[63:32]  = v.data[95:64];
                w[95:64]  = v.data[63:32];
                w[127:96] = v.data[31:0] & 32'hFFFF_FFFE;
            end
        end
        return w;
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] a, c;
        logic [2:0] expf;
        a = 32'h1000_0000 + idx * 32'h0101;
        c = 32'(idx + 3) | (32'(v.resp) << 6) | (32'(v.lng) << 7) | (32'd1 << 10);
        @(negedge clk);
        arg_we = 1; arg_wdata = a; cmd_we = 1; cmd_wdata = c;
        @(negedge clk);
        arg_we = 0; cmd_we = 0;
        chk(card_cmd_valid && busy, "R2 strobe", {busy, card_cmd_valid}, 2'b11);
        chk(card_cmd_index == c[5:0], "R2 index", card_cmd_index, c[5:0]);
        chk(card_cmd_arg == a, "R2 arg", card_cmd_arg, a);
        chk({flag_rsp_end, flag_sent, flag_timeout} == 3'b0, "R11 cleared",
            {flag_rsp_end, flag_sent, flag_timeout}, 0);
        @(negedge clk);
        chk(!card_cmd_valid && busy, "R2 wait", {busy, card_cmd_valid}, 2'b10);
        card_rsp_valid = 1; card_rsp_reject = v.rej;
        card_rsp_len = v.len; card_rsp_data = v.data;
        @(negedge clk);
        card_rsp_valid = 0;
        model_w = next_words(v, model_w);
        expf = (v.outcome == 2'd0) ? 3'b100 : (v.outcome == 2'd1) ? 3'b010 : 3'b001;
        chk({flag_rsp_end, flag_sent, flag_timeout} == expf, "R5-R9 flags R7 R8 R9",
            {flag_rsp_end, flag_sent, flag_timeout}, expf);
        chk(rsp_words == model_w, "R5 R6 words", rsp_words, model_w);
        chk(!busy && cmd_q == (c & ~32'h400), "R3 enable cleared", cmd_q, c & ~32'h400);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(arg_q == 0 && cmd_q == 0 && rsp_words == 0, "R1 regs", {arg_q, cmd_q}, 0);
        chk({busy, card_cmd_valid, flag_rsp_end, flag_sent, flag_timeout} == 0,
            "R1 ctrl", {busy, card_cmd_valid, flag_rsp_end, flag_sent, flag_timeout}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R4 pending command: bits 10 and 9 set
        @(negedge clk);
        cmd_we = 1; cmd_wdata = 32'h0000_0605;
        @(negedge clk);
        cmd_we = 0;
        chk(!card_cmd_valid && !busy, "R4 no strobe", {busy, card_cmd_valid}, 0);
        chk(cmd_q == 32'h0000_0205, "R4 stored", cmd_q, 32'h205);
        @(negedge clk);
        chk(!card_cmd_valid && !busy, "R4 still idle", {busy, card_cmd_valid}, 0);
        chk(flag_timeout == 1'b1, "R11 flags hold on pending", flag_timeout, 1);

        // R10 writes while busy ignored
        @(negedge clk);
        arg_we = 1; arg_wdata = 32'hCAFE_0001; cmd_we = 1; cmd_wdata = 32'h0000_0402;
        @(negedge clk);
        arg_we = 0; cmd_we = 0;
        @(negedge clk);
        arg_we = 1; arg_wdata = 32'h0BAD_0BAD; cmd_we = 1; cmd_wdata = 32'h0000_04C7;
        @(negedge clk);
        arg_we = 0; cmd_we = 0;
        chk(arg_q == 32'hCAFE_0001, "R10 arg ignored", arg_q, 32'hCAFE_0001);
        chk(cmd_q == 32'h0000_0402, "R10 cmd ignored", cmd_q, 32'h402);
        card_rsp_valid = 1; card_rsp_reject = 0; card_rsp_len = 5'd0;
        @(negedge clk);
        card_rsp_valid = 0;
        chk(flag_sent && !busy && cmd_q == 32'h0000_0002, "R10 R8 completion",
            {flag_sent, busy, cmd_q}, {1'b1, 1'b0, 32'h2});
        @(negedge clk);
        chk(!card_cmd_valid && !busy, "R10 no extra strobe", {busy, card_cmd_valid}, 0);
        chk(rsp_words == model_w, "R8 words unchanged", rsp_words, model_w);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule